// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block performs one of nine 32-bit integer operations per cycle, chosen by an opcode. Four of them are add or subtract operations that clamp to the representable limit instead of wrapping, in signed or unsigned form. A fifth is a plain wrapping add that only reports signed overflow. The other four clamp a value into an N-bit signed or unsigned range, either over the whole word or over each 16-bit half on its own. The result path is purely combinational.

Any clamp or overflow event raises a single sticky flag. The flag is a register updated on the clock edge while the valid strobe is high. Software uses a separate write port to clear the flag or load a chosen value, and that write wins over an event in the same cycle. Typical use: issue a run of operations, then read the flag once to learn whether any of them clipped.

Top module: `sat_alu_unit`

## Requirements
- R1: Opcode 0 (signed add): when both operands have the same sign and the wrapped sum has the other sign, the result is 0x7FFFFFFF for a non-negative first operand and 0x80000000 for a negative one, and this is an event. Otherwise the result is the wrapped sum.
- R2: Opcode 1 (signed subtract, a minus b): when the operand signs differ and the wrapped difference's sign differs from a, the result clamps to the same two values as R1 and this is an event. Otherwise the result is the wrapped difference.
- R3: Opcode 2 (unsigned add): if the true sum exceeds 0xFFFFFFFF, the result is 0xFFFFFFFF and this is an event. Otherwise the result is the sum.
- R4: Opcode 3 (unsigned subtract): if b is greater than a, the result is 0 and this is an event. Otherwise the result is a minus b.
- R5: Opcode 4 (flagging add): the result is always the wrapped sum, and signed overflow as defined in R1 is an event.
- R6: Opcode 5 (signed width clamp): for width s on the sat_width port, a signed a above 2^s−1 gives 2^s−1, a below −2^s gives −2^s, and both are events. Any other a passes through unchanged.
- R7: Opcode 6 (unsigned width clamp): a negative signed a gives 0, an a above 2^s−1 gives 2^s−1, and both are events. Any other a passes through unchanged.
- R8: Opcodes 7 and 8 (dual-lane signed and unsigned clamp): bits 15:0 and bits 31:16 of a are each sign-extended and clamped as in R6 or R7 with the same s. The low lane's result, cut to 16 bits, goes to bits 15:0, and the high lane's result goes to bits 31:16. An event in either lane is an event.
- R9: On a clock edge with in_valid high, an event sets sticky_flag. No operation ever clears it, and with in_valid low no event changes it.
- R10: On a clock edge with flag_wr_en high, sticky_flag takes the value of flag_wr_val, even when an event is present in the same cycle.
- R11: A synchronous active-high reset clears sticky_flag to 0.
- R12: Opcodes 9 to 15 give a result of 0 and never raise an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the operation for the sticky flag update |
| op | input | 4 | Operation select (0 to 8 defined) |
| opnd_a | input | 32 | First operand, or the value to clamp |
| opnd_b | input | 32 | Second operand for add and subtract |
| sat_width | input | 5 | Clamp width s for opcodes 5 to 8 |
| flag_wr_en | input | 1 | Software write strobe for the sticky flag |
| flag_wr_val | input | 1 | Value loaded into the sticky flag |
| result | output | 32 | Combinational result |
| sticky_flag | output | 1 | Registered sticky saturation flag |

## Verification
The bench builds the unit at its default 32-bit word with 16-bit lanes, because the clamp limits and overflow boundaries of interest sit exactly at those widths. At that size, every one of the 32 clamp widths can be swept for all four clamp opcodes against a set of boundary and lane-straddling values, and every add and subtract opcode can be crossed over all pairs of eight boundary operands. A reference model built on 64-bit signed arithmetic computes the expected results and events. Between vectors the flag is cleared through the write port, so each vector's event is seen on its own at the flag output.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;
  typedef enum logic [3:0] {
    OP_SADD      = 4'd0,
    OP_SSUB      = 4'd1,
    OP_UADD      = 4'd2,
    OP_USUB      = 4'd3,
    OP_ADD_FLAG  = 4'd4,
    OP_SCLAMP    = 4'd5,
    OP_UCLAMP    = 4'd6,
    OP_SCLAMP_X2 = 4'd7,
    OP_UCLAMP_X2 = 4'd8
  } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
`timescale 1ns/1ps
module sat_addsub
  import sat_pkg::*;
#(
  parameter int W = 32
) (
  input  sat_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           evt
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   sum_ext;
  logic [W-1:0] dif;
  logic         s_ovf_add, s_ovf_sub, u_carry, u_borrow;
  logic [W-1:0] s_limit;

  always_comb begin
    sum_ext   = {1'b0, a} + {1'b0, b};
    dif       = a - b;
    s_ovf_add = (a[W-1] == b[W-1]) && (sum_ext[W-1] != a[W-1]);
    s_ovf_sub = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
    u_carry   = sum_ext[W];
    u_borrow  = (b > a);
    s_limit   = a[W-1] ? SMIN : SMAX;
    res       = '0;
    evt       = 1'b0;
    case (op)
      OP_SADD: begin
        res = s_ovf_add ? s_limit : sum_ext[W-1:0];
        evt = s_ovf_add;
      end
      OP_SSUB: begin
        res = s_ovf_sub ? s_limit : dif;
        evt = s_ovf_sub;
      end
      OP_UADD: begin
        res = u_carry ? {W{1'b1}} : sum_ext[W-1:0];
        evt = u_carry;
      end
      OP_USUB: begin
        res = u_borrow ? '0 : dif;
        evt = u_borrow;
      end
      OP_ADD_FLAG: begin
        res = sum_ext[W-1:0];
        evt = s_ovf_add;
      end
      default: begin
        res = '0;
        evt = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sat_clamp.sv
`timescale 1ns/1ps
module sat_clamp #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] sh,
  input  logic          is_signed,
  output logic [W-1:0]  res,
  output logic          evt
);
  logic [W-1:0] top;
  logic [W-1:0] mask;
  logic         above, below;

  always_comb begin
    top  = W'($signed(val) >>> sh);
    mask = (W'(1) << sh) - W'(1);
    if (is_signed) begin
      above = !top[W-1] && (|top);
      below = top[W-1] && !(&top);
      if (above)      res = mask;
      else if (below) res = ~mask;
      else            res = val;
      evt = above || below;
    end else begin
      below = val[W-1];
      above = !val[W-1] && (val > mask);
      if (below)      res = '0;
      else if (above) res = mask;
      else            res = val;
      evt = above || below;
    end
  end
endmodule

// File: rtl/sat_sticky_flag.sv
`timescale 1ns/1ps
module sat_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (wr_en)   flag_q <= wr_val;
    else if (set_req) flag_q <= 1'b1;
  end

  assert_wr_load_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flag_q == $past(wr_val)));
  assert_never_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !wr_en) |=> flag_q);
  assert_set_on_event_R9: assert property (@(posedge clk) disable iff (rst)
    (set_req && !wr_en) |=> flag_q);
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!set_req && !wr_en) |=> $stable(flag_q));
endmodule

// File: rtl/sat_alu_unit.sv
`timescale 1ns/1ps
module sat_alu_unit
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SH_W-1:0]   sat_width,
  input  logic              flag_wr_en,
  input  logic              flag_wr_val,
  output logic [DATA_W-1:0] result,
  output logic              sticky_flag
);
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  sat_op_e op_e;
  assign op_e = sat_op_e'(op);

  logic              clamp_signed;
  logic [DATA_W-1:0] as_res;
  logic              as_evt;
  logic [DATA_W-1:0] full_res;
  logic              full_evt;
  logic [DATA_W-1:0] lane_in  [LANES];
  logic [DATA_W-1:0] lane_res [LANES];
  logic [LANES-1:0]  lane_evt;
  logic [DATA_W-1:0] dual_res;
  logic              any_evt;

  assign clamp_signed = (op_e == OP_SCLAMP) || (op_e == OP_SCLAMP_X2);

  sat_addsub #(.W(DATA_W)) u_addsub (
    .op  (op_e),
    .a   (opnd_a),
    .b   (opnd_b),
    .res (as_res),
    .evt (as_evt)
  );

  sat_clamp #(.W(DATA_W), .SW(SH_W)) u_clamp_full (
    .val       (opnd_a),
    .sh        (sat_width),
    .is_signed (clamp_signed),
    .res       (full_res),
    .evt       (full_evt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_in[g] = {{(DATA_W-LANE_W){opnd_a[g*LANE_W+LANE_W-1]}},
                         opnd_a[g*LANE_W +: LANE_W]};
    sat_clamp #(.W(DATA_W), .SW(SH_W)) u_clamp_lane (
      .val       (lane_in[g]),
      .sh        (sat_width),
      .is_signed (clamp_signed),
      .res       (lane_res[g]),
      .evt       (lane_evt[g])
    );
    assign dual_res[g*LANE_W +: LANE_W] = lane_res[g][LANE_W-1:0];
  end

  always_comb begin
    result  = '0;
    any_evt = 1'b0;
    case (op_e)
      OP_SADD, OP_SSUB, OP_UADD, OP_USUB, OP_ADD_FLAG: begin
        result  = as_res;
        any_evt = as_evt;
      end
      OP_SCLAMP, OP_UCLAMP: begin
        result  = full_res;
        any_evt = full_evt;
      end
      OP_SCLAMP_X2, OP_UCLAMP_X2: begin
        result  = dual_res;
        any_evt = |lane_evt;
      end
      default: begin
        result  = '0;
        any_evt = 1'b0;
      end
    endcase
  end

  sat_sticky_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .set_req (in_valid && any_evt),
    .wr_en   (flag_wr_en),
    .wr_val  (flag_wr_val),
    .flag_q  (sticky_flag)
  );

  assert_sadd_sign_R1: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0 && opnd_a[DATA_W-1] == opnd_b[DATA_W-1])
      |-> (result[DATA_W-1] == opnd_a[DATA_W-1]));
  assert_uadd_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd2) |-> (result >= opnd_a));
  assert_usub_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd3) |-> (result <= opnd_a));
  assert_uclamp_range_R7: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd6) |-> (result <= ((DATA_W'(1) << sat_width) - DATA_W'(1))));
  assert_undef_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (op > 4'd8) |-> (result == '0));
endmodule

// File: tb/test_sat_alu_unit.sv
`timescale 1ns/1ps
module test_sat_alu_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [4:0]  sat_width = '0;
  logic        flag_wr_en = 1'b0;
  logic        flag_wr_val = 1'b0;
  logic [31:0] result;
  logic        sticky_flag;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sat_alu_unit i_sat_alu_unit (
    .clk, .rst, .in_valid, .op, .opnd_a, .opnd_b, .sat_width,
    .flag_wr_en, .flag_wr_val, .result, .sticky_flag
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h s=%0d actual=%h expected=%h",
               req, op, opnd_a, opnd_b, sat_width, act, exp);
    end
  endtask

  function automatic void clamp_ref(input longint v, input int s, input bit sgn,
                                    output longint r, output bit e);
    longint hi = (longint'(1) <<< s) - 1;
    longint lo = -(longint'(1) <<< s);
    e = 1'b0; r = v;
    if (sgn) begin
      if (v > hi) begin r = hi; e = 1'b1; end
      else if (v < lo) begin r = lo; e = 1'b1; end
    end else begin
      if (v < 0) begin r = 0; e = 1'b1; end
      else if (v > hi) begin r = hi; e = 1'b1; end
    end
  endfunction

  function automatic void ref_model(input int o, input logic [31:0] a, input logic [31:0] b,
                                    input int s, output logic [31:0] r, output bit e,
                                    output string req);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'd0, a});
    longint ub = longint'({32'd0, b});
    longint t, rl, rh;
    bit el, eh;
    r = '0; e = 1'b0; req = "R12";
    case (o)
      0: begin req = "R1"; t = sa + sb;
         if (t > 64'sd2147483647) begin r = 32'h7FFFFFFF; e = 1; end
         else if (t < -64'sd2147483648) begin r = 32'h80000000; e = 1; end
         else r = t[31:0]; end
      1: begin req = "R2"; t = sa - sb;
         if (t > 64'sd2147483647) begin r = 32'h7FFFFFFF; e = 1; end
         else if (t < -64'sd2147483648) begin r = 32'h80000000; e = 1; end
         else r = t[31:0]; end
      2: begin req = "R3"; t = ua + ub;
         if (t > 64'sd4294967295) begin r = 32'hFFFFFFFF; e = 1; end
         else r = t[31:0]; end
      3: begin req = "R4";
         if (ub > ua) begin r = 0; e = 1; end else r = a - b; end
      4: begin req = "R5"; t = sa + sb; r = a + b;
         e = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      5, 6: begin req = (o == 5) ? "R6" : "R7";
         clamp_ref(sa, s, o == 5, t, e); r = t[31:0]; end
      7, 8: begin req = "R8";
         clamp_ref(longint'($signed(a[15:0])), s, o == 7, rl, el);
         clamp_ref(longint'($signed(a[31:16])), s, o == 7, rh, eh);
         r = {rh[15:0], rl[15:0]}; e = el || eh; end
      default: begin r = '0; e = 0; req = "R12"; end
    endcase
  endfunction

  task automatic run_vec(input int o, input logic [31:0] a, input logic [31:0] b, input int s);
    logic [31:0] er;
    bit ee;
    string req;
    @(negedge clk);
    flag_wr_en = 1'b1; flag_wr_val = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    flag_wr_en = 1'b0;
    op = 4'(o); opnd_a = a; opnd_b = b; sat_width = 5'(s); in_valid = 1'b1;
    #1;
    ref_model(o, a, b, s, er, ee, req);
    chk(req, result, er);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk({req, "/R9 flag"}, {31'd0, sticky_flag}, {31'd0, ee});
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                              32'hFFFFFFFF, 32'h80000001, 32'h7FFFFFFE, 32'h00010000};
    logic [31:0] cvals [12] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                                32'hFFFFFFFF, 32'h80000001, 32'h00010000, 32'h7FFF8000,
                                32'h00017FFF, 32'hFFFF0001, 32'h8000FFFF, 32'h12345678};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 chk("R11 reset", {31'd0, sticky_flag}, 32'd0);

    // R11: reset clears a loaded flag
    @(negedge clk); flag_wr_en = 1'b1; flag_wr_val = 1'b1;
    @(negedge clk); flag_wr_en = 1'b0; #1 chk("R10 load 1", {31'd0, sticky_flag}, 32'd1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1 chk("R11 reset after load", {31'd0, sticky_flag}, 32'd0);

    for (int o = 0; o < 5; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_vec(o, vals[i], vals[j], 0);
    for (int o = 5; o < 9; o++)
      for (int i = 0; i < 12; i++)
        for (int s = 0; s < 32; s++)
          run_vec(o, cvals[i], 32'h0, s);
    for (int o = 9; o < 16; o++)
      run_vec(o, 32'h7FFFFFFF, 32'h1, 3);

    // R10: write wins over a same-cycle event
    @(negedge clk);
    flag_wr_en = 1'b1; flag_wr_val = 1'b0;
    op = 4'd0; opnd_a = 32'h7FFFFFFF; opnd_b = 32'h1; in_valid = 1'b1;
    @(negedge clk); flag_wr_en = 1'b0; in_valid = 1'b0;
    #1 chk("R10 write priority", {31'd0, sticky_flag}, 32'd0);

    // R9: event without in_valid leaves flag clear
    @(negedge clk); #1 chk("R9 no valid no set", {31'd0, sticky_flag}, 32'd0);

    // R9: set, then a clean operation does not clear it
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); op = 4'd0; opnd_a = 32'h1; opnd_b = 32'h1;
    #1 chk("R9 set", {31'd0, sticky_flag}, 32'd1);
    @(negedge clk); in_valid = 1'b0;
    #1 chk("R9 sticky hold", {31'd0, sticky_flag}, 32'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule